// File: doc/BRIEF.md
# Zero-Run Vertical Sync Detector

This block watches a stream of 8-bit digitized video samples, one per clock, and raises a flag when the vertical sync interval is present. The video front end clamps the signal so that the sync tip converts to a sample value of exactly zero. Horizontal sync pulses produce only short runs of zeros. The wider pulses inside the vertical interval produce much longer runs. The block measures the length of the current unbroken run of zero samples and flags the cycle in which that run reaches 127. A run of that length can only come from a vertical sync pulse.

The run counter is 7 bits wide and is built as a 4-bit low stage and a 3-bit high stage. A registered look-ahead carry joins the two stages. The carry is loaded while the low stage sits one step below its top value, so it is already valid when the low stage rolls over. This keeps each stage's next-state logic narrow. Any nonzero sample clears the whole counter and the carry, so the block measures run length rather than a total count of zeros. A downstream controller uses the flag to decide when to start capturing a frame.

Top module: `vsync_zero_run_detect`

## Requirements
- R1: A synchronous reset held over a clock edge clears the run counter and the carry. `vsync_o` is low in the cycle after reset, and a new run counts from zero.
- R2: Each clock edge that captures a sample equal to 8'h00 increases the run length by exactly one.
- R3: A sample with any bit set, whichever bit it is, clears the run length to zero on that edge. The next zero sample then starts a new run at one.
- R4: `vsync_o` is high exactly when the current run of consecutive zero samples has length 127. After 126 zeros it stays low. It goes high in the cycle after the edge that captures the 127th zero.
- R5: The counter wraps rather than saturates. A further zero after 127 returns the run length to 0, so the flag lasts exactly one cycle. It rises again after another 128 zeros.
- R6: A nonzero sample while the run length is 127 clears the counter, and the flag falls in the next cycle.
- R7: The high stage advances only on an edge where the registered low-stage carry is set. The carry is set only while the low stage holds 15. The combined count stays exact across every low-stage rollover, including a run that is broken just after a rollover.
- R8: Runs shorter than 127 zeros, such as those from horizontal sync pulses separated by nonzero video, never raise `vsync_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock; one video sample per rising edge |
| rst | input | 1 | Synchronous active-high reset |
| sample_i | input | 8 | Digitized video sample; 8'h00 marks the sync level |
| vsync_o | output | 1 | High for one cycle when the zero run reaches 127 |

## Verification
The bound checker covers the following on every cycle:
- The reset clear.
- The clear on any nonzero sample.
- The exact increment by one with wraparound on a zero sample.
- The relation between the carry and the low stage holding 15.
- The hold of the high stage when no carry is present.
- The one-cycle width of the flag.

Only the bench's scenarios can show other properties:
- The flag fires at run length 127 and not at 126.
- Each individual sample bit breaks a run.
- A run broken right after a low-stage rollover restarts cleanly.
- Horizontal-length bursts never trigger the flag.

// File: rtl/vsd_pkg.sv
package vsd_pkg;
  // Default geometry of the zero-run detector
  localparam int unsigned VSD_SAMPLE_W = 8;
  localparam int unsigned VSD_LO_W     = 4;
  localparam int unsigned VSD_HI_W     = 3;
  localparam int unsigned VSD_CNT_W    = VSD_LO_W + VSD_HI_W;
endpackage

// File: rtl/vsd_zero_qual.sv
module vsd_zero_qual #(
  parameter int unsigned SAMPLE_W = vsd_pkg::VSD_SAMPLE_W
) (
  input  logic [SAMPLE_W-1:0] sample_i,
  output logic                is_zero_o
);
  // Sync tip is clamped to code zero; any set bit means active video
  always_comb is_zero_o = ~|sample_i;
endmodule

// File: rtl/vsd_lo_stage.sv
module vsd_lo_stage #(
  parameter int unsigned LO_W = vsd_pkg::VSD_LO_W
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            clr,
  output logic [LO_W-1:0] cnt_q,
  output logic            carry_q
);
  // Value one below the stage top: carry is loaded here so it is
  // already valid while the stage holds its top value.
  localparam logic [LO_W-1:0] PRE_TOP = {{(LO_W-1){1'b1}}, 1'b0};

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt_q   <= '0;
      carry_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_q + 1'b1;
      carry_q <= (cnt_q == PRE_TOP);
    end
  end
endmodule

// File: rtl/vsd_hi_stage.sv
module vsd_hi_stage #(
  parameter int unsigned HI_W = vsd_pkg::VSD_HI_W
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            clr,
  input  logic            step,
  output logic [HI_W-1:0] cnt_q
);
  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt_q <= '0;
    end else if (step) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/vsync_zero_run_detect.sv
module vsync_zero_run_detect #(
  parameter int unsigned SAMPLE_W = vsd_pkg::VSD_SAMPLE_W,
  parameter int unsigned LO_W     = vsd_pkg::VSD_LO_W,
  parameter int unsigned HI_W     = vsd_pkg::VSD_HI_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [SAMPLE_W-1:0] sample_i,
  output logic                vsync_o
);
  localparam int unsigned CNT_W = LO_W + HI_W;

  logic            is_zero;
  logic            clr;
  logic [LO_W-1:0] lo_q;
  logic [HI_W-1:0] hi_q;
  logic            carry_q;
  logic [CNT_W-1:0] run_len;

  vsd_zero_qual #(.SAMPLE_W(SAMPLE_W)) u_zero (
    .sample_i (sample_i),
    .is_zero_o(is_zero)
  );

  assign clr = ~is_zero;

  vsd_lo_stage #(.LO_W(LO_W)) u_lo (
    .clk    (clk),
    .rst    (rst),
    .clr    (clr),
    .cnt_q  (lo_q),
    .carry_q(carry_q)
  );

  vsd_hi_stage #(.HI_W(HI_W)) u_hi (
    .clk  (clk),
    .rst  (rst),
    .clr  (clr),
    .step (carry_q),
    .cnt_q(hi_q)
  );

  // Flag decodes registered state only: all-ones run length
  assign run_len = {hi_q, lo_q};
  assign vsync_o = &run_len;
endmodule

// File: rtl/vsd_checker.sv
module vsd_checker #(
  parameter int unsigned SAMPLE_W = vsd_pkg::VSD_SAMPLE_W,
  parameter int unsigned LO_W     = vsd_pkg::VSD_LO_W,
  parameter int unsigned HI_W     = vsd_pkg::VSD_HI_W
) (
  input logic                clk,
  input logic                rst,
  input logic [SAMPLE_W-1:0] sample_i,
  input logic                vsync_o,
  input logic [LO_W-1:0]     lo_q,
  input logic [HI_W-1:0]     hi_q,
  input logic                carry_q
);
  localparam int unsigned CNT_W = LO_W + HI_W;

  logic rst_d = 1'b0;
  always @(posedge clk) rst_d <= rst;

  always @(negedge clk) begin
    if (rst_d) begin
      AST_RESET_CLEAR: assert ({hi_q, lo_q} == '0 && !carry_q && !vsync_o) else $error("reset clear"); // R1
    end
  end

  AST_ZERO_STEP: assert property (@(posedge clk) disable iff (rst)
    (sample_i == '0) |=> ({hi_q, lo_q} == CNT_W'($past({hi_q, lo_q}) + 1'b1))) else $error("zero step"); // R2

  AST_NONZERO_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (sample_i != '0) |=> ({hi_q, lo_q} == '0 && !carry_q)) else $error("nonzero clear"); // R3

  AST_FLAG_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    vsync_o |=> !vsync_o) else $error("flag width"); // R5

  AST_FLAG_AFTER_ZERO: assert property (@(posedge clk) disable iff (rst)
    $rose(vsync_o) |-> ($past(sample_i) == '0)) else $error("flag cause"); // R4

  AST_CARRY_ALIGN: assert property (@(posedge clk) disable iff (rst)
    carry_q |-> (&lo_q)) else $error("carry align"); // R7

  AST_HI_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!carry_q && sample_i == '0) |=> $stable(hi_q)) else $error("hi hold"); // R7
endmodule

bind vsync_zero_run_detect vsd_checker #(
  .SAMPLE_W(SAMPLE_W),
  .LO_W    (LO_W),
  .HI_W    (HI_W)
) u_vsd_chk (
  .clk     (clk),
  .rst     (rst),
  .sample_i(sample_i),
  .vsync_o (vsync_o),
  .lo_q    (lo_q),
  .hi_q    (hi_q),
  .carry_q (carry_q)
);

// File: tb/tb_vsync_zero_run_detect.sv
module tb_vsync_zero_run_detect;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] sample = 8'h00;
  logic       vsync;

  int checks = 0;
  int failures = 0;
  int run_model = 0;
  bit finished = 1'b0;

  vsync_zero_run_detect dut (
    .clk     (clk),
    .rst     (rst),
    .sample_i(sample),
    .vsync_o (vsync)
  );

  always #10 clk = ~clk;

  // Behavioural reference: length of current zero run, modulo 128
  always @(posedge clk) begin
    if (rst || sample != 8'h00) run_model <= 0;
    else                        run_model <= (run_model + 1) % 128;
  end

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: vsync actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  // Every-cycle comparison against the model (R4, R8)
  always @(negedge clk) begin
    if (!finished) chk("R4/R8 cycle", vsync, run_model == 127);
  end

  task automatic step(input logic [7:0] v);
    sample = v;
    @(negedge clk);
  endtask

  task automatic zeros(input int n);
    for (int i = 0; i < n; i++) step(8'h00);
  endtask

  task automatic summary;
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: actual=timeout expected=done");
    summary();
  end

  initial begin
    rst = 1'b1;
    zeros(3);
    chk("R1 reset", vsync, 1'b0);
    rst = 1'b0;

    // R4 threshold edge
    zeros(126);
    chk("R4 at 126", vsync, 1'b0);
    zeros(1);
    chk("R4 at 127", vsync, 1'b1);
    // R5 wrap, single-cycle flag
    zeros(1);
    chk("R5 wrap", vsync, 1'b0);
    zeros(126);
    chk("R5 wrap 126", vsync, 1'b0);
    zeros(1);
    chk("R5 second flag", vsync, 1'b1);
    // R6 nonzero at 127
    step(8'h80);
    chk("R6 clear at 127", vsync, 1'b0);

    // R7 break just after low-stage rollover
    zeros(16);
    step(8'h01);
    zeros(126);
    chk("R7 after 16 break", vsync, 1'b0);
    zeros(1);
    chk("R7 exact 127", vsync, 1'b1);
    zeros(15);
    step(8'h04);
    zeros(127);
    chk("R7 after 15 break", vsync, 1'b1);

    // R2 and R3: each sample bit clears; exact count afterwards
    for (int b = 0; b < 8; b++) begin
      zeros(100);
      step(8'(1 << b));
      chk("R3 bit clear", vsync, 1'b0);
      zeros(126);
      chk("R2 recount 126", vsync, 1'b0);
      zeros(1);
      chk("R2 recount 127", vsync, 1'b1);
    end

    // R8 horizontal-length bursts
    begin
      bit saw = 1'b0;
      for (int l = 0; l < 20; l++) begin
        for (int i = 0; i < 40 + l * 4; i++) begin
          step(8'h00);
          if (vsync) saw = 1'b1;
        end
        step(8'h30);
        if (vsync) saw = 1'b1;
      end
      chk("R8 no flag on short runs", saw, 1'b0);
    end

    // R1 mid-run reset
    zeros(120);
    rst = 1'b1;
    step(8'h00);
    rst = 1'b0;
    chk("R1 mid-run reset", vsync, 1'b0);
    zeros(126);
    chk("R1 restart 126", vsync, 1'b0);
    zeros(1);
    chk("R1 restart 127", vsync, 1'b1);

    step(8'hFF);
    summary();
  end
endmodule